// File: doc/BRIEF.md
# ECP Reverse-Channel Receiver with Run-Length Expansion

This block sits on the host side of an extended-capability parallel link and handles the reverse direction, from peripheral to host. It first completes the post-negotiation setup step. On command it turns the bus around, so the port data lines become inputs and the peripheral may drive them. It then takes one byte per strobe/acknowledge handshake. A kind line from the peripheral marks each byte as data or as a command.

Command bytes are decoded on the fly. A command with the top bit set addresses a channel and is dropped. A command with the top bit clear carries a run length. The next data byte is then emitted once and repeated that many extra times on a valid/ready byte stream. The bus handshake is held off until every repeat has been accepted downstream.

A second command turns the bus back to the forward direction. Every wait on a peripheral line has a timeout counted in ticks of a divided clock. A timeout raises a sticky error flag.

Top module: `ecp_rev_rx`

## Requirements
- R1: While reset is asserted, and in the cycle after it, the pin outputs take these values: host_ack_n_o=1, rev_req_n_o=1, dir_in_o=0. In the same cycles out_valid_o=0 and err_o=0.
- R2: When idle in forward mode, cmd_setup_i lowers host_ack_n_o. If per_rack_n_i is seen high within RESP_TICKS ticks, the block reaches forward-ECP with host_ack_n_o low and err_o clear. Otherwise err_o sets and the block returns to idle with host_ack_n_o high.
- R3: In forward-ECP, cmd_rev_i raises dir_in_o at once while rev_req_n_o stays high. After SETUP_TICKS ticks, rev_req_n_o falls. The block then waits for per_rack_n_i low and enters reverse-idle. In idle forward mode (host_ack_n_o high, dir_in_o low), cmd_rev_i has no effect.
- R4: A byte latched while per_kind_i=1 (data) is driven on out_data_o with out_valid_o high. Both stay stable until out_ready_i is high, and host_ack_n_o stays low until the byte is accepted.
- R5: After a byte is latched (and accepted, for data), host_ack_n_o rises. Once per_strobe_n_i is seen high, host_ack_n_o falls again.
- R6: A byte latched while per_kind_i=0 with bit 7 = 1 (channel address) produces no output.
- R7: A byte latched while per_kind_i=0 with bit 7 = 0 loads bits 6:0 as a run count N. The next data byte appears N+1 times in total, so N=0 gives one copy. A later run command that arrives before the data byte replaces N.
- R8: Repeat copies are offered back to back, one per cycle with out_ready_i high. While they are offered, host_ack_n_o stays low and no new strobe is taken.
- R9: In reverse-idle, cmd_fwd_i raises rev_req_n_o with dir_in_o still high. Once per_rack_n_i is seen high, the block raises host_ack_n_o and lowers dir_in_o together.
- R10: A timeout sets err_o and puts the block in reverse-idle with host_ack_n_o low. This covers the strobe-release wait (RESP_TICKS) and the idle wait for a strobe (IDLE_TICKS). err_o stays set until a command is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_setup_i | input | 1 | start the post-negotiation setup step |
| cmd_rev_i | input | 1 | turn the bus to reverse direction |
| cmd_fwd_i | input | 1 | turn the bus back to forward direction |
| per_strobe_n_i | input | 1 | peripheral byte strobe, active low |
| per_kind_i | input | 1 | 1 = data byte, 0 = command byte |
| per_rack_n_i | input | 1 | peripheral turnaround acknowledge |
| per_data_i | input | DATA_W | peripheral data lines |
| host_ack_n_o | output | 1 | host handshake line |
| rev_req_n_o | output | 1 | reverse request, active low |
| dir_in_o | output | 1 | 1 = port data lines are inputs |
| out_data_o | output | DATA_W | output byte |
| out_valid_o | output | 1 | output byte valid |
| out_ready_i | input | 1 | downstream ready |
| err_o | output | 1 | sticky timeout flag |

## Verification
Each peripheral line passes SYNC_STAGES flops. A pin change made at a falling edge therefore reaches the state register at the third rising edge by default. A command takes effect at the first rising edge that sees it. A timeout fires limit × TICK_DIV cycles after its state is entered. The bench drives at falling edges and samples at falling edges, and waits for each pin response inside a bounded window rather than at a fixed cycle. Command responses are checked at the first falling edge after the command is taken. Output bytes are compared by a monitor at the rising edge where valid and ready meet, against a queue the stimulus tasks fill in the order the requirements dictate.

// File: rtl/ecp_rx_pkg.sv
package ecp_rx_pkg;

   typedef enum logic [3:0] {
      ST_FWD,
      ST_SETUP,
      ST_ECPF,
      ST_TURN_SU,
      ST_TURN_W,
      ST_REV,
      ST_OUT,
      ST_ACKH,
      ST_RPT,
      ST_BACK
   } rx_state_e;

   typedef struct packed {
      logic host_ack_n;
      logic rev_req_n;
      logic dir_in;
   } pin_drive_t;

   function automatic pin_drive_t drive_for(rx_state_e s);
      pin_drive_t p;
      case (s)
         ST_FWD:                         p = '{1'b1, 1'b1, 1'b0};
         ST_SETUP, ST_ECPF:              p = '{1'b0, 1'b1, 1'b0};
         ST_TURN_SU, ST_BACK:            p = '{1'b0, 1'b1, 1'b1};
         ST_ACKH:                        p = '{1'b1, 1'b0, 1'b1};
         ST_TURN_W, ST_REV, ST_OUT,
         ST_RPT:                         p = '{1'b0, 1'b0, 1'b1};
         default:                        p = '{1'b1, 1'b1, 1'b0};
      endcase
      return p;
   endfunction

   function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/ecp_in_sync.sv
module ecp_in_sync #(
   parameter int unsigned W       = 8,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES == 0) begin : g_none
         assign q = d;
      end else begin : g_sync
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/ecp_tick_timer.sv
module ecp_tick_timer #(
   parameter int unsigned TICK_DIV = 1,
   parameter int unsigned CNT_W    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);

   logic             tick;
   logic [CNT_W-1:0] tick_q;

   generate
      if (TICK_DIV == 1) begin : g_nodiv
         assign tick = 1'b1;
      end else begin : g_div
         localparam int unsigned DW = $clog2(TICK_DIV);
         localparam logic [DW-1:0] DIV_LAST = DW'(TICK_DIV - 1);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk) begin
            if (!rst_n || restart)      div_q <= '0;
            else if (div_q == DIV_LAST) div_q <= '0;
            else                        div_q <= div_q + 1'b1;
         end
         assign tick = (div_q == DIV_LAST);
      end
   endgenerate

   assign expired = (tick_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n || restart)     tick_q <= '0;
      else if (tick && !expired) tick_q <= tick_q + 1'b1;
   end

endmodule

// File: rtl/ecp_byte_class.sv
module ecp_byte_class #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned RUN_W = DATA_W - 1
) (
   input  logic [DATA_W-1:0] byte_i,
   input  logic              kind_i,
   output logic              is_data_o,
   output logic              is_chan_o,
   output logic              is_run_o,
   output logic [RUN_W-1:0]  run_len_o
);

   assign is_data_o = kind_i;
   assign is_chan_o = !kind_i &&  byte_i[DATA_W-1];
   assign is_run_o  = !kind_i && !byte_i[DATA_W-1];
   assign run_len_o = byte_i[RUN_W-1:0];

endmodule

// File: rtl/ecp_run_ctl.sv
module ecp_run_ctl #(
   parameter int unsigned DATA_W = 8,
   localparam int unsigned RUN_W = DATA_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              load_i,
   input  logic [RUN_W-1:0]  len_i,
   input  logic              take_i,
   input  logic [DATA_W-1:0] byte_i,
   input  logic              pop_i,
   output logic              owed_o,
   output logic              last_o,
   output logic [DATA_W-1:0] rpt_byte_o
);

   logic [RUN_W-1:0]  cnt_q;
   logic              pend_q;
   logic [DATA_W-1:0] rpt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clear_i) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else if (load_i) begin
         cnt_q  <= len_i;
         pend_q <= 1'b1;
      end else if (take_i) begin
         pend_q <= 1'b0;
      end else if (pop_i && cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                rpt_q <= '0;
      else if (take_i && pend_q) rpt_q <= byte_i;
   end

   assign owed_o     = (cnt_q != '0) && !pend_q;
   assign last_o     = (cnt_q == RUN_W'(1));
   assign rpt_byte_o = rpt_q;

endmodule

// File: rtl/ecp_rev_rx.sv
module ecp_rev_rx
   import ecp_rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned TICK_DIV    = 50,
   parameter int unsigned SETUP_TICKS = 1,
   parameter int unsigned RESP_TICKS  = 6,
   parameter int unsigned IDLE_TICKS  = 2000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_setup_i,
   input  logic              cmd_rev_i,
   input  logic              cmd_fwd_i,
   input  logic              per_strobe_n_i,
   input  logic              per_kind_i,
   input  logic              per_rack_n_i,
   input  logic [DATA_W-1:0] per_data_i,
   output logic              host_ack_n_o,
   output logic              rev_req_n_o,
   output logic              dir_in_o,
   output logic [DATA_W-1:0] out_data_o,
   output logic              out_valid_o,
   input  logic              out_ready_i,
   output logic              err_o
);

   localparam int unsigned RUN_W = DATA_W - 1;
   localparam int unsigned SW    = DATA_W + 3;
   localparam int unsigned MAXT  = max3(SETUP_TICKS, RESP_TICKS, IDLE_TICKS);
   localparam int unsigned CNT_W = $clog2(MAXT + 1);
   localparam logic [SW-1:0] SYNC_RST = {1'b1, 1'b0, 1'b1, {DATA_W{1'b0}}};

   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (TICK_DIV < 1) begin : g_bad_div
         $error("TICK_DIV must be at least 1");
      end
      if (SETUP_TICKS < 1 || RESP_TICKS < 1) begin : g_bad_t
         $error("tick limits must be at least 1");
      end
      if (IDLE_TICKS < RESP_TICKS) begin : g_bad_idle
         $error("IDLE_TICKS must not be below RESP_TICKS");
      end
   endgenerate

   // synchronized peripheral lines
   logic [SW-1:0]     sync_q;
   logic              s_strobe_n, s_kind, s_rack_n;
   logic [DATA_W-1:0] s_data;

   ecp_in_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({per_strobe_n_i, per_kind_i, per_rack_n_i, per_data_i}),
      .q     (sync_q)
   );
   assign {s_strobe_n, s_kind, s_rack_n, s_data} = sync_q;

   // byte classification
   logic             c_data, c_chan, c_run;
   logic [RUN_W-1:0] c_len;

   ecp_byte_class #(.DATA_W(DATA_W)) u_class (
      .byte_i    (s_data),
      .kind_i    (s_kind),
      .is_data_o (c_data),
      .is_chan_o (c_chan),
      .is_run_o  (c_run),
      .run_len_o (c_len)
   );

   // state and control
   rx_state_e         st_q, st_nx;
   logic              restart, rearm, expired;
   logic [CNT_W-1:0]  limit;
   logic              err_set, err_clr, err_q;
   logic              latch, run_clear, run_load, run_take, run_pop;
   logic              owed, last;
   logic [DATA_W-1:0] rpt_byte, hold_q;

   ecp_tick_timer #(.TICK_DIV(TICK_DIV), .CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (limit),
      .expired (expired)
   );

   ecp_run_ctl #(.DATA_W(DATA_W)) u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (run_clear),
      .load_i     (run_load),
      .len_i      (c_len),
      .take_i     (run_take),
      .byte_i     (s_data),
      .pop_i      (run_pop),
      .owed_o     (owed),
      .last_o     (last),
      .rpt_byte_o (rpt_byte)
   );

   always_comb begin
      case (st_q)
         ST_TURN_SU: limit = CNT_W'(SETUP_TICKS);
         ST_REV:     limit = CNT_W'(IDLE_TICKS);
         default:    limit = CNT_W'(RESP_TICKS);
      endcase
   end

   always_comb begin
      st_nx     = st_q;
      err_set   = 1'b0;
      err_clr   = 1'b0;
      rearm     = 1'b0;
      latch     = 1'b0;
      run_clear = 1'b0;
      run_load  = 1'b0;
      run_take  = 1'b0;
      run_pop   = 1'b0;
      case (st_q)
         ST_FWD: begin
            if (cmd_setup_i) begin
               st_nx   = ST_SETUP;
               err_clr = 1'b1;
            end
         end
         ST_SETUP: begin
            if (s_rack_n) st_nx = ST_ECPF;
            else if (expired) begin
               st_nx   = ST_FWD;
               err_set = 1'b1;
            end
         end
         ST_ECPF: begin
            if (cmd_rev_i) begin
               st_nx   = ST_TURN_SU;
               err_clr = 1'b1;
            end
         end
         ST_TURN_SU: begin
            if (expired) st_nx = ST_TURN_W;
         end
         ST_TURN_W: begin
            if (!s_rack_n) st_nx = ST_REV;
            else if (expired) begin
               st_nx   = ST_REV;
               err_set = 1'b1;
            end
         end
         ST_REV: begin
            if (owed) begin
               st_nx = ST_RPT;
            end else if (cmd_fwd_i) begin
               st_nx     = ST_BACK;
               err_clr   = 1'b1;
               run_clear = 1'b1;
            end else if (!s_strobe_n) begin
               latch = 1'b1;
               if (c_data) begin
                  run_take = 1'b1;
                  st_nx    = ST_OUT;
               end else if (c_run) begin
                  run_load = 1'b1;
                  st_nx    = ST_ACKH;
               end else if (c_chan) begin
                  st_nx = ST_ACKH;
               end
            end else if (expired) begin
               err_set = 1'b1;
               rearm   = 1'b1;
            end
         end
         ST_OUT: begin
            if (out_ready_i) st_nx = ST_ACKH;
         end
         ST_ACKH: begin
            if (s_strobe_n) st_nx = ST_REV;
            else if (expired) begin
               st_nx   = ST_REV;
               err_set = 1'b1;
            end
         end
         ST_RPT: begin
            if (out_ready_i) begin
               run_pop = 1'b1;
               if (last) st_nx = ST_REV;
            end
         end
         ST_BACK: begin
            if (s_rack_n) st_nx = ST_FWD;
            else if (expired) begin
               st_nx   = ST_REV;
               err_set = 1'b1;
            end
         end
         default: st_nx = ST_FWD;
      endcase
   end

   assign restart = (st_nx != st_q) || rearm;

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_FWD;
      else        st_q <= st_nx;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       err_q <= 1'b0;
      else if (err_set) err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     hold_q <= '0;
      else if (latch) hold_q <= s_data;
   end

   pin_drive_t pins;
   assign pins         = drive_for(st_q);
   assign host_ack_n_o = pins.host_ack_n;
   assign rev_req_n_o  = pins.rev_req_n;
   assign dir_in_o     = pins.dir_in;
   assign out_valid_o  = (st_q == ST_OUT) || (st_q == ST_RPT);
   assign out_data_o   = (st_q == ST_RPT) ? rpt_byte : hold_q;
   assign err_o        = err_q;

endmodule

// File: rtl/ecp_rev_rx_chk.sv
module ecp_rev_rx_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_setup_i,
   input logic              cmd_rev_i,
   input logic              cmd_fwd_i,
   input logic              host_ack_n_o,
   input logic              rev_req_n_o,
   input logic              dir_in_o,
   input logic [DATA_W-1:0] out_data_o,
   input logic              out_valid_o,
   input logic              out_ready_i,
   input logic              err_o
);

   AST_RESET_PINS: assert property (@(posedge clk)
      !rst_n |=> (host_ack_n_o && rev_req_n_o && !dir_in_o && !out_valid_o && !err_o)); // R1

   AST_REV_IGNORED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_ack_n_o && !dir_in_o && cmd_rev_i) |=> !dir_in_o); // R3

   AST_REVREQ_NEEDS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      !rev_req_n_o |-> dir_in_o); // R3

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o))); // R4

   AST_ACK_LOW_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid_o |-> (!host_ack_n_o && dir_in_o && !rev_req_n_o)); // R8

   AST_DIR_DROP_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dir_in_o) |-> (host_ack_n_o && rev_req_n_o)); // R9

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !cmd_setup_i && !cmd_rev_i && !cmd_fwd_i) |=> err_o); // R10

endmodule

bind ecp_rev_rx ecp_rev_rx_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_ecp_rev_rx.sv
module sim_ecp_rev_rx;

   localparam int CLK_PERIOD = 10;
   localparam int TD    = 2;
   localparam int RESP  = 6;
   localparam int IDLE  = 200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_setup = 1'b0, cmd_rev = 1'b0, cmd_fwd = 1'b0;
   logic       strobe_n = 1'b1, kind = 1'b0, rack_n = 1'b0;
   logic [7:0] pdata = 8'h00;
   logic       host_ack_n, rev_req_n, dir_in, out_valid, err;
   logic [7:0] out_data;
   logic       out_ready = 1'b1;

   int n_tests = 0;
   int n_fail  = 0;
   int rdy_mode = 0;
   int cyc = 0;
   bit done = 0;
   logic [7:0] exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ecp_rev_rx #(.DATA_W(8), .TICK_DIV(TD), .SETUP_TICKS(1), .RESP_TICKS(RESP),
                .IDLE_TICKS(IDLE), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n),
      .cmd_setup_i(cmd_setup), .cmd_rev_i(cmd_rev), .cmd_fwd_i(cmd_fwd),
      .per_strobe_n_i(strobe_n), .per_kind_i(kind), .per_rack_n_i(rack_n),
      .per_data_i(pdata),
      .host_ack_n_o(host_ack_n), .rev_req_n_o(rev_req_n), .dir_in_o(dir_in),
      .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
      .err_o(err));

   always @(posedge clk) begin
      cyc <= cyc + 1;
      case (rdy_mode)
         1:       out_ready <= cyc[1];
         2:       out_ready <= 1'b0;
         default: out_ready <= 1'b1;
      endcase
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: compares each accepted byte against the queue
   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) check(0, "R6 unexpected output", out_data, 0);
         else begin
            logic [7:0] e;
            e = exp_q.pop_front();
            check(out_data == e, "R4 R7 output byte", out_data, e);
         end
      end
   end

   task automatic pulse(input int which);
      @(negedge clk);
      if (which == 0) cmd_setup = 1'b1;
      else if (which == 1) cmd_rev = 1'b1;
      else cmd_fwd = 1'b1;
      @(negedge clk);
      cmd_setup = 1'b0; cmd_rev = 1'b0; cmd_fwd = 1'b0;
   endtask

   task automatic wait_ack(input logic v, output bit ok);
      ok = 0;
      for (int i = 0; i < 4000; i++) begin
         if (host_ack_n === v) begin ok = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic wait_rev(input logic v, output bit ok);
      ok = 0;
      for (int i = 0; i < 200; i++) begin
         if (rev_req_n === v) begin ok = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic wait_err(input int lim, output bit ok);
      ok = 0;
      for (int i = 0; i < lim; i++) begin
         if (err === 1'b1) begin ok = 1; break; end
         @(negedge clk);
      end
   endtask

   task automatic send(input logic k, input logic [7:0] b);
      bit ok1, ok2;
      @(negedge clk);
      pdata = b; kind = k;
      @(negedge clk);
      strobe_n = 1'b0;
      wait_ack(1'b1, ok1);
      @(negedge clk);
      strobe_n = 1'b1;
      wait_ack(1'b0, ok2);
      check(ok1 && ok2, "R5 handshake", {ok1, ok2}, 2'b11);
   endtask

   task automatic go_reverse();
      bit ok;
      rack_n = 1'b1;
      pulse(0);
      repeat (8) @(negedge clk);
      pulse(1);
      check(dir_in == 1'b1 && rev_req_n == 1'b1 && host_ack_n == 1'b0,
            "R3 direction first", {dir_in, rev_req_n, host_ack_n}, 3'b110);
      wait_rev(1'b0, ok);
      check(ok, "R3 reverse request", rev_req_n, 0);
      @(negedge clk);
      rack_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   initial begin
      bit ok;
      repeat (3) @(negedge clk);
      check(host_ack_n == 1 && rev_req_n == 1 && dir_in == 0 && out_valid == 0 && err == 0,
            "R1 reset", {host_ack_n, rev_req_n, dir_in, out_valid, err}, 5'b11000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3: turnaround request ignored in idle forward mode
      pulse(1);
      repeat (10) @(negedge clk);
      check(dir_in == 0 && rev_req_n == 1, "R3 ignored in idle", {dir_in, rev_req_n}, 2'b01);

      // R2: setup with no response times out
      rack_n = 1'b0;
      pulse(0);
      check(host_ack_n == 0, "R2 setup lowers ack", host_ack_n, 0);
      wait_err(200, ok);
      check(ok && host_ack_n == 1, "R2 setup timeout", {ok, host_ack_n}, 2'b11);

      // R2 success, R3 turnaround
      go_reverse();
      check(err == 0 && host_ack_n == 0 && dir_in == 1 && rev_req_n == 0,
            "R2 R3 reverse idle", {err, host_ack_n, dir_in, rev_req_n}, 4'b0010);

      // R4: plain data bytes, no backpressure then toggling backpressure
      exp_q.push_back(8'hA5); send(1'b1, 8'hA5);
      exp_q.push_back(8'h5A); send(1'b1, 8'h5A);
      rdy_mode = 1;
      exp_q.push_back(8'hC3); send(1'b1, 8'hC3);

      // R4: stall downstream, byte and ack must hold
      rdy_mode = 2;
      @(negedge clk); pdata = 8'h66; kind = 1'b1;
      @(negedge clk); strobe_n = 1'b0;
      repeat (12) @(negedge clk);
      check(out_valid == 1 && out_data == 8'h66 && host_ack_n == 0,
            "R4 hold under stall", {out_valid, out_data, host_ack_n}, {1'b1, 8'h66, 1'b0});
      exp_q.push_back(8'h66);
      rdy_mode = 0;
      wait_ack(1'b1, ok);
      @(negedge clk); strobe_n = 1'b1;
      wait_ack(1'b0, ok);
      check(ok, "R5 after stall", host_ack_n, 0);

      // R6: channel address command dropped
      send(1'b0, 8'h85);
      exp_q.push_back(8'h11); send(1'b1, 8'h11);

      // R7 R8: run of 3 extra copies with backpressure
      rdy_mode = 1;
      send(1'b0, 8'h03);
      for (int i = 0; i < 4; i++) exp_q.push_back(8'h3C);
      send(1'b1, 8'h3C);
      exp_q.push_back(8'hE1); send(1'b1, 8'hE1);
      rdy_mode = 0;

      // R7: zero run length gives a single copy
      send(1'b0, 8'h00);
      exp_q.push_back(8'h77); send(1'b1, 8'h77);

      // R7: later run command replaces earlier count
      send(1'b0, 8'h02);
      send(1'b0, 8'h05);
      for (int i = 0; i < 6; i++) exp_q.push_back(8'h9A);
      send(1'b1, 8'h9A);
      repeat (12) @(negedge clk);
      check(exp_q.size() == 0, "R7 R8 all copies emitted", exp_q.size(), 0);
      check(host_ack_n == 0 && out_valid == 0, "R8 back to idle", {host_ack_n, out_valid}, 2'b00);

      // R10: strobe never released after ack raised
      @(negedge clk); pdata = 8'h81; kind = 1'b0;
      @(negedge clk); strobe_n = 1'b0;
      wait_ack(1'b1, ok);
      wait_err(200, ok);
      check(ok && host_ack_n == 0 && dir_in == 1, "R10 release timeout",
            {ok, host_ack_n, dir_in}, 3'b101);
      @(negedge clk); strobe_n = 1'b1;
      wait_ack(1'b0, ok);
      repeat (6) @(negedge clk);
      check(err == 1, "R10 error sticky", err, 1);

      // R9: back to forward
      pulse(2);
      check(rev_req_n == 1 && dir_in == 1 && host_ack_n == 0 && err == 0,
            "R9 reverse released", {rev_req_n, dir_in, host_ack_n, err}, 4'b1100);
      @(negedge clk); rack_n = 1'b1;
      wait_ack(1'b1, ok);
      check(ok && dir_in == 0 && rev_req_n == 1, "R9 forward restored",
            {ok, dir_in, rev_req_n}, 3'b101);

      // R10: idle timeout waiting for a strobe
      go_reverse();
      repeat (IDLE * TD / 2) @(negedge clk);
      check(err == 0, "R10 no early idle timeout", err, 0);
      wait_err(IDLE * TD, ok);
      check(ok && host_ack_n == 0 && rev_req_n == 0, "R10 idle timeout",
            {ok, host_ack_n, rev_req_n}, 3'b100);
      exp_q.push_back(8'h5E); send(1'b1, 8'h5E);
      repeat (6) @(negedge clk);
      check(exp_q.size() == 0, "R10 transfer after timeout", exp_q.size(), 0);

      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual expired expected finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule